// File: doc/BRIEF.md
# Glyph Blitter

The block draws a rectangular character cell into a byte-per-pixel frame buffer. The source is a packed glyph image with one bit per pixel. Each bit becomes one destination pixel whose palette index is built from a programmable paint colour. A caller loads the job operands and pulses `start`. The block then walks the cell row by row over a single byte-wide memory port. It fetches glyph bytes and issues pixel writes. Each pixel write replaces a whole byte, so no destination byte is ever read back.

Two mode controls shape the output. The pattern control decides whether glyph bits are used at all. With the pattern off, the cell comes out as a solid block of the paint colour. The transparency control makes pixels whose glyph bit equals a chosen value (0 or 1) leave the frame buffer untouched. Opaque pixels receive the paint colour XOR the glyph bit. Software can therefore make two transparent passes over the same cell with opposite transparent values to get independent foreground and background colours.

Top module: `glyphBlitter`

## Requirements
- R1: After reset `busy`, `done` and `memReq` are all low.
- R2: Pixel (x, y) of the cell goes to byte address `dstBase + y*dstPitch + x`, taken modulo 2^20. Pixels are visited with x running fastest: row 0 left to right first, then row 1, and so on.
- R3: With the pattern on, glyph bytes are read from consecutive addresses starting at `srcAddr`, one byte for each started group of 8 pixels in a row. Each row starts on a fresh byte. Bit 7 of a glyph byte is the leftmost pixel of its group.
- R4: With the pattern on and transparency off, every pixel is written with `paintColor ^ bit`.
- R5: With the pattern on and transparency on, a pixel whose glyph bit equals `transpValue` produces no write. Every other pixel is written with `paintColor ^ bit`.
- R6: With the pattern off, no glyph read is issued and every pixel of the cell is written with `paintColor`, whatever the transparency controls hold.
- R7: A raised `memReq` keeps `memWe`, `memAddr` and, for a write, `memWdata` stable until the cycle in which `memReady` is high. Only one request is outstanding at a time. Read data is taken from `memRdata` in that handshake cycle.
- R8: A `start` seen while `busy` is high is ignored, and the running job's output does not change. `busy` is high from the cycle after an accepted start through the cycle in which `done` is high.
- R9: `done` is high for exactly one cycle, the cycle after the last pixel of the cell is finished (its write accepted or its skip decided).
- R10: A start with zero width or zero height issues no memory request and still produces the one-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start strobe, sampled only when idle |
| srcAddr | input | 20 | Byte address of the first glyph byte |
| dstBase | input | 20 | Destination address of pixel (0,0) |
| dstPitch | input | 16 | Destination bytes per row |
| blitWidth | input | 8 | Cell width in pixels |
| blitHeight | input | 8 | Cell height in rows |
| paintColor | input | 8 | Paint palette index |
| transpEn | input | 1 | Transparency enable |
| transpValue | input | 1 | Glyph bit value treated as see-through |
| patternEn | input | 1 | Use glyph bits (0 = solid block) |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 20 | Request byte address |
| memWdata | output | 8 | Write data |
| memReady | input | 1 | Request accepted this cycle |
| memRdata | input | 8 | Read data, valid in the handshake cycle |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after row padding with a 10-pixel-wide cell. A design that kept reading the glyph stream across a row edge would draw skewed rows there. It runs both transparent values over the same glyph, which catches a design that inverts the skip test or writes the paint colour without the XOR. It also runs a solid block with transparency left on; a design that still reads glyph bytes or skips pixels in that mode would show up. Further runs cover a cell that wraps the top of the address space, which catches truncated address arithmetic, and cells with zero width or height, which must finish without touching memory. A restart pulsed in the middle of a job must not disturb the write stream. The bench throttles `memReady` to check that requests are held, and a design that moved its address or data early would be reported.

// File: rtl/glyphBlitPkg.sv
package glyphBlitPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;     // capture job operands, reset counters
    logic fetchLd;  // take a glyph byte, bump the source pointer
    logic advance;  // move to the next pixel
    logic wrSel;    // memory address shows the destination
  } blitStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PIX,
    ST_FETCH,
    ST_EVAL,
    ST_WRITE,
    ST_FIN
  } blitStateT;

endpackage

// File: rtl/glyphBlitData.sv
module glyphBlitData
  import glyphBlitPkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 8,
  parameter int COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  blitStrobeT         strb,
  input  logic [ADDR_W-1:0]  srcAddrIn,
  input  logic [ADDR_W-1:0]  dstBaseIn,
  input  logic [PITCH_W-1:0] pitchIn,
  input  logic [DIM_W-1:0]   widthIn,
  input  logic [DIM_W-1:0]   heightIn,
  input  logic [COLOR_W-1:0] paintIn,
  input  logic               transpEnIn,
  input  logic               transpValIn,
  input  logic               patEnIn,
  input  logic [7:0]         memRdata,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [COLOR_W-1:0] memWdata,
  output logic               needFetch,
  output logic               skipPix,
  output logic               lastPix,
  output logic               emptyJob
);

  localparam int BIT_IDX_W = 3;  // pixels per glyph byte = 2**BIT_IDX_W

  logic [ADDR_W-1:0]  srcPtr, rowAddr, dstAddr;
  logic [PITCH_W-1:0] pitchReg;
  logic [DIM_W-1:0]   wReg, hReg, xCnt, yCnt;
  logic [COLOR_W-1:0] paintReg;
  logic               transpEn, transpVal, patEn;
  logic [7:0]         srcByte;
  logic               curBit, lastCol, lastRow;

  assign lastCol  = (xCnt == wReg - DIM_W'(1));
  assign lastRow  = (yCnt == hReg - DIM_W'(1));
  assign lastPix  = lastCol && lastRow;
  assign emptyJob = (widthIn == '0) || (heightIn == '0);

  assign curBit    = srcByte[BIT_IDX_W'(7) - xCnt[BIT_IDX_W-1:0]];
  assign needFetch = patEn && (xCnt[BIT_IDX_W-1:0] == '0);
  assign skipPix   = patEn && transpEn && (curBit == transpVal);

  assign dstAddr  = rowAddr + ADDR_W'(xCnt);
  assign memAddr  = strb.wrSel ? dstAddr : srcPtr;
  assign memWdata = patEn ? (paintReg ^ COLOR_W'(curBit)) : paintReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr    <= '0;
      rowAddr   <= '0;
      pitchReg  <= '0;
      wReg      <= '0;
      hReg      <= '0;
      xCnt      <= '0;
      yCnt      <= '0;
      paintReg  <= '0;
      transpEn  <= 1'b0;
      transpVal <= 1'b0;
      patEn     <= 1'b0;
      srcByte   <= '0;
    end else if (strb.load) begin
      srcPtr    <= srcAddrIn;
      rowAddr   <= dstBaseIn;
      pitchReg  <= pitchIn;
      wReg      <= widthIn;
      hReg      <= heightIn;
      xCnt      <= '0;
      yCnt      <= '0;
      paintReg  <= paintIn;
      transpEn  <= transpEnIn;
      transpVal <= transpValIn;
      patEn     <= patEnIn;
    end else begin
      if (strb.fetchLd) begin
        srcByte <= memRdata;
        srcPtr  <= srcPtr + ADDR_W'(1);
      end
      if (strb.advance && !lastPix) begin
        if (lastCol) begin
          xCnt    <= '0;
          yCnt    <= yCnt + DIM_W'(1);
          rowAddr <= rowAddr + ADDR_W'(pitchReg);
        end else begin
          xCnt <= xCnt + DIM_W'(1);
        end
      end
    end
  end

  // R2: the column counter never leaves the cell once a job is loaded
  assert_col_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wReg != '0) |-> (xCnt < wReg));

  // R2: the row counter never leaves the cell once a job is loaded
  assert_row_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hReg != '0) |-> (yCnt < hReg));

endmodule

// File: rtl/glyphBlitCtrl.sv
module glyphBlitCtrl
  import glyphBlitPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memReady,
  input  logic       needFetch,
  input  logic       skipPix,
  input  logic       lastPix,
  input  logic       emptyJob,
  output blitStrobeT strb,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);

  blitStateT state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.load = 1'b1;
        nextState = emptyJob ? ST_FIN : ST_PIX;
      end
      ST_PIX:   nextState = needFetch ? ST_FETCH : ST_EVAL;
      ST_FETCH: begin
        memReq = 1'b1;
        if (memReady) begin
          strb.fetchLd = 1'b1;
          nextState    = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (skipPix) begin
          strb.advance = 1'b1;
          nextState    = lastPix ? ST_FIN : ST_PIX;
        end else begin
          nextState = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        strb.wrSel = 1'b1;
        if (memReady) begin
          strb.advance = 1'b1;
          nextState    = lastPix ? ST_FIN : ST_PIX;
        end
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R7: a pending request stays raised with the same direction
  assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe)));

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: no traffic once the job has completed
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

endmodule

// File: rtl/glyphBlitter.sv
module glyphBlitter
  import glyphBlitPkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 8,
  parameter int COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  srcAddr,
  input  logic [ADDR_W-1:0]  dstBase,
  input  logic [PITCH_W-1:0] dstPitch,
  input  logic [DIM_W-1:0]   blitWidth,
  input  logic [DIM_W-1:0]   blitHeight,
  input  logic [COLOR_W-1:0] paintColor,
  input  logic               transpEn,
  input  logic               transpValue,
  input  logic               patternEn,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [COLOR_W-1:0] memWdata,
  input  logic               memReady,
  input  logic [7:0]         memRdata,
  output logic               busy,
  output logic               done
);

  blitStrobeT strb;
  logic needFetch, skipPix, lastPix, emptyJob;

  glyphBlitCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memReady  (memReady),
    .needFetch (needFetch),
    .skipPix   (skipPix),
    .lastPix   (lastPix),
    .emptyJob  (emptyJob),
    .strb      (strb),
    .memReq    (memReq),
    .memWe     (memWe),
    .busy      (busy),
    .done      (done)
  );

  glyphBlitData #(
    .ADDR_W  (ADDR_W),
    .PITCH_W (PITCH_W),
    .DIM_W   (DIM_W),
    .COLOR_W (COLOR_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .srcAddrIn   (srcAddr),
    .dstBaseIn   (dstBase),
    .pitchIn     (dstPitch),
    .widthIn     (blitWidth),
    .heightIn    (blitHeight),
    .paintIn     (paintColor),
    .transpEnIn  (transpEn),
    .transpValIn (transpValue),
    .patEnIn     (patternEn),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .needFetch   (needFetch),
    .skipPix     (skipPix),
    .lastPix     (lastPix),
    .emptyJob    (emptyJob)
  );

  // R7: address and write data hold while the request waits
  assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> ($stable(memAddr) && (!memWe || $stable(memWdata))));

  // R1: an idle block issues no request
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

endmodule

// File: tb/tb_glyphBlitter.sv
module tb_glyphBlitter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [19:0] srcAddr = '0, dstBase = '0;
  logic [15:0] dstPitch = '0;
  logic [7:0]  blitWidth = '0, blitHeight = '0, paintColor = '0;
  logic        transpEn = 1'b0, transpValue = 1'b0, patternEn = 1'b0;
  logic        memReq, memWe, memReady = 1'b0, busy, done;
  logic [19:0] memAddr;
  logic [7:0]  memWdata, memRdata;

  logic [7:0]  srcMem [0:255];
  logic [27:0] expW [$];
  logic [19:0] expR [$];
  int checks = 0, failures = 0;
  int slowReady = 0;
  string curTag = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memRdata = srcMem[memAddr[7:0]];

  glyphBlitter dut (
    .clk(clk), .rstN(rstN), .start(start), .srcAddr(srcAddr), .dstBase(dstBase),
    .dstPitch(dstPitch), .blitWidth(blitWidth), .blitHeight(blitHeight),
    .paintColor(paintColor), .transpEn(transpEn), .transpValue(transpValue),
    .patternEn(patternEn), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ready generator: changes just after each rising edge
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      cnt++;
      memReady = (slowReady == 0) ? 1'b1 : ((cnt % 3) == 0);
    end
  end

  // monitor: pops the scoreboard as requests are accepted
  logic        pend = 1'b0, pWe = 1'b0;
  logic [19:0] pAddr = '0;
  logic [7:0]  pData = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pend) begin
        check(memReq && memWe == pWe && memAddr == pAddr && (!pWe || memWdata == pData),
              "R7", "request held", {memReq, memAddr}, {1'b1, pAddr});
      end
      pend  = memReq && !memReady;
      pAddr = memAddr; pWe = memWe; pData = memWdata;
      if (memReq && memReady) begin
        if (memWe) begin
          if (expW.size() == 0) check(0, curTag, "unexpected write", {memAddr, memWdata}, 0);
          else begin
            logic [27:0] e;
            e = expW.pop_front();
            check({memAddr, memWdata} == e, curTag, "write addr/data", {memAddr, memWdata}, e);
          end
        end else begin
          if (expR.size() == 0) check(0, "R3", "unexpected read", memAddr, 0);
          else begin
            logic [19:0] r;
            r = expR.pop_front();
            check(memAddr == r, "R3", "read address", memAddr, r);
          end
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic runJob(input int src, input int base, input int pitch, input int w,
                        input int h, input int pc, input bit te, input bit tv,
                        input bit pe, input bit poke, input string tag);
    int nb, waitCnt;
    nb = (w + 7) / 8;
    curTag = tag;
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        bit b;
        logic [7:0] sb;
        if (pe && (x % 8) == 0) expR.push_back(20'(src + y*nb + x/8));
        sb = srcMem[8'(src + y*nb + x/8)];
        b = sb[7 - (x % 8)];
        if (!(pe && te && b == tv))
          expW.push_back({20'(base + y*pitch + x), pe ? (8'(pc) ^ {7'b0, b}) : 8'(pc)});
      end
    end
    @(negedge clk);
    srcAddr = 20'(src); dstBase = 20'(base); dstPitch = 16'(pitch);
    blitWidth = 8'(w); blitHeight = 8'(h); paintColor = 8'(pc);
    transpEn = te; transpValue = tv; patternEn = pe; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      check(busy == 1'b1, "R8", "busy before restart poke", busy, 1);
      srcAddr = 20'h00063; dstBase = 20'h55555; paintColor = 8'hEE; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      srcAddr = 20'(src); dstBase = 20'(base); paintColor = 8'(pc);
    end
    waitCnt = 0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done == 1'b1, "R9", "done seen", done, 1);
    check(expW.size() == 0, tag, "writes left over", expW.size(), 0);
    check(expR.size() == 0, "R3", "reads left over", expR.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done one cycle", done, 0);
    check(busy == 1'b0, "R8", "idle after done", busy, 0);
    expW.delete();
    expR.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) srcMem[i] = 8'(i * 37 + 5);
    srcMem[8'h10] = 8'hA5; srcMem[8'h11] = 8'h80;
    srcMem[8'h12] = 8'h3C; srcMem[8'h13] = 8'h40;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && memReq == 0, "R1", "reset outputs",
          {busy, done, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && memReq == 0, "R1", "after reset release",
          {busy, done, memReq}, 0);

    // R4 and R3: 10-wide cell, two glyph bytes per row with padding
    runJob(16'h10, 20'h0A000, 720, 10, 3, 8'h40, 0, 0, 1, 0, "R4");
    // R5: transparent zeros, slow memory
    slowReady = 1;
    runJob(16'h20, 20'h01000, 64, 8, 4, 8'h11, 1, 0, 1, 0, "R5");
    // R5: transparent ones on the same glyph
    runJob(16'h20, 20'h01000, 64, 8, 4, 8'h22, 1, 1, 1, 0, "R5");
    // R6: solid block, transparency left on
    runJob(16'h30, 20'h02000, 100, 5, 2, 8'h7C, 1, 0, 0, 0, "R6");
    // R2: destination wraps at the top of the address space
    slowReady = 0;
    runJob(16'h40, 20'hFFFF0, 32, 20, 2, 8'h90, 0, 0, 1, 0, "R2");
    // R10: empty cells
    runJob(16'h50, 20'h03000, 16, 0, 3, 8'h01, 0, 0, 1, 0, "R10");
    runJob(16'h50, 20'h03000, 16, 4, 0, 8'h01, 0, 0, 0, 0, "R10");
    // R8: restart pulse in mid-job is ignored
    slowReady = 1;
    runJob(16'h60, 20'h04000, 40, 16, 4, 8'h33, 1, 0, 1, 1, "R8");
    slowReady = 0;
    repeat (3) @(negedge clk);
    summary();
  end

endmodule